// File: doc/BRIEF.md
# Multi-function compare timer

This block is one 16-bit timer channel with two compare units, meant for periodic interrupts and for watchdog duty. Software reaches it through four word registers: compare 1 at word index 0, compare 2 at word index 1, the counter at word index 2 and the setup word at word index 3 (byte offsets 0x0, 0x2, 0x4, 0x6 on the host side). The counter advances once every 2^N source ticks, where N is a 4-bit shift code. The source is either the block clock or an external tick-enable input.

Each compare unit has a 2-bit mode and a sticky flag that drives its own interrupt line. Compare 2 also ends the counting period, because the counter goes back to zero after it. While the reset-arm input is high, a compare 2 hit also raises a system reset request. To restart the watchdog, software writes 0 to the counter and the timeout value to compare 2.

A lock bit in the setup word freezes the configuration until the next reset. A stop-enable bit lets an external halt input freeze counting.

Top module: `cmp_timer`

## Requirements
- R1: After reset, all four registers read 0, and `irq_cmp1`, `irq_cmp2` and `wdt_rst_req` are low.
- R2: With setup bit 15 (count enable) set and prescale code N in setup bits 3:0, the counter rises by one every 2^N source ticks. The prescale phase restarts from zero whenever counting is disabled or the counter is written. For example, with N=3 the counter reads 2 after 23 clocks and 3 after 24 clocks.
- R3: Setup bit 4 selects the source. With bit 4 at 0, every clock is a source tick. With bit 4 at 1, only clocks with `alt_tick` high are source ticks.
- R4: Compare modes sit in setup bits 7:6 for unit 1 and 9:8 for unit 2, coded 0 = off, 1 = equal, 2 = greater-or-equal, 3 = event. In mode off a unit never sets its flag. In equal mode the flag is set one cycle after the counter equals the compare value. Each flag drives its interrupt output directly.
- R5: In greater-or-equal mode the flag is set one cycle after the counter holds any value not below the compare value, including a value written directly to the counter.
- R6: In event mode the flag is set only when the counter has just advanced onto the compare value. A value written directly to the counter that equals the compare value does not set the flag.
- R7: Flags read back in setup bit 13 (unit 1) and bit 14 (unit 2). They stay set until a setup write with 1 in that bit clears them. Writing 0 to a flag bit leaves the flag unchanged.
- R8: When compare 2 is not off and the counter meets its condition (equal, or greater-or-equal in mode 2), the next counter tick loads 0 instead of incrementing.
- R9: `wdt_rst_req` is high in the cycle after a compare 2 hit only if `rst_arm` was high during the hit. If software rewrites the counter to 0 before it reaches compare 2, no request is raised.
- R10: The timeout may be 0xFFFF. The counter reaches 0xFFFF and then wraps to 0, and compare 2 flags the hit.
- R11: Once a setup write sets bit 12 (lock), later setup writes leave bits 0 to 12 and bit 15 unchanged until reset. Flag clearing still works while locked.
- R12: With setup bit 11 (stop enable) set, the counter and the prescaler hold while `halt_in` is high. With bit 11 clear, `halt_in` has no effect.
- R13: Setup bit 10 always reads 0. Setup bit 5 and the compare registers read back what was written. A counter write takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_widx | input | 2 | Word index of the write (0 compare 1, 1 compare 2, 2 counter, 3 setup) |
| bus_wdata | input | 16 | Write data |
| bus_ridx | input | 2 | Word index of the read |
| bus_rdata | output | 16 | Read data, combinational from `bus_ridx` |
| alt_tick | input | 1 | Tick enable from the alternate source |
| halt_in | input | 1 | External halt, honoured when stop enable is set |
| rst_arm | input | 1 | Reset enable for compare 2, from a separate mask register |
| irq_cmp1 | output | 1 | Compare 1 flag |
| irq_cmp2 | output | 1 | Compare 2 flag |
| wdt_rst_req | output | 1 | System reset request from compare 2 |

## Verification
The counter is run with prescale codes 0 and 3 and sampled on both sides of a prescale boundary, which separates a correct shift decode from an off-by-one phase. It is also run from the alternate tick source with that source held off and then pulsed. Directly written counter values are placed against the compare values in each mode. Equal mode fires on an exact written match, greater-or-equal mode fires on an overshoot, and event mode ignores a written match but fires on a counted step. Compare 2 is exercised for wrap-around with a small value, with a value below an overshooting counter, and with the maximum 0xFFFF. These runs are repeated with the reset arm high and low, and with periodic counter restarts, to show when a reset request may appear.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    localparam int DW   = 16;
    localparam int PSW  = 4;
    localparam int NCMP = 2;

    typedef enum logic [1:0] {
        CM_OFF = 2'd0,
        CM_EQ  = 2'd1,
        CM_GE  = 2'd2,
        CM_EVT = 2'd3
    } cmp_mode_e;

    typedef enum logic [1:0] {
        RG_CMP1  = 2'd0,
        RG_CMP2  = 2'd1,
        RG_CNT   = 2'd2,
        RG_SETUP = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic           cnt_en;   // 15
        logic           flag2;    // 14
        logic           flag1;    // 13
        logic           lock;     // 12
        logic           stop_en;  // 11
        logic           rsvd;     // 10
        cmp_mode_e      mode2;    // 9:8
        cmp_mode_e      mode1;    // 7:6
        logic           rev_en;   // 5
        logic           clk_sel;  // 4
        logic [PSW-1:0] pscode;   // 3:0
    } setup_t;

    function automatic setup_t strip_status(setup_t s);
        setup_t r;
        r       = s;
        r.flag1 = 1'b0;
        r.flag2 = 1'b0;
        r.rsvd  = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/cmt_prescale.sv
module cmt_prescale #(
    parameter int PSW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           src_en,
    input  logic [PSW-1:0] code,
    output logic           tick
);
    localparam int PW = (1 << PSW) - 1;

    logic [PW-1:0] phase_q;
    logic [PW-1:0] mask;

    always_comb begin
        mask = (PW'(1) << code) - PW'(1);
        tick = src_en && ((phase_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            phase_q <= '0;
        else if (src_en)
            phase_q <= phase_q + PW'(1);
    end
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    input  logic         wrap,
    output logic [W-1:0] cnt,
    output logic         adv
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            adv <= 1'b0;
        end else begin
            adv <= tick && !load;
            if (load)
                cnt <= load_val;
            else if (tick)
                cnt <= wrap ? '0 : cnt + W'(1);
        end
    end
endmodule

// File: rtl/cmt_compare.sv
module cmt_compare
    import cmp_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  cmp_mode_e    mode,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] ref_v,
    input  logic         adv,
    input  logic         clr,
    output logic         hit,
    output logic         reach,
    output logic         flag
);
    logic eq, ge;

    always_comb begin
        eq = (cnt == ref_v);
        ge = (cnt >= ref_v);
        case (mode)
            CM_EQ:   begin hit = eq;        reach = eq; end
            CM_GE:   begin hit = ge;        reach = ge; end
            CM_EVT:  begin hit = eq && adv; reach = eq; end
            default: begin hit = 1'b0;      reach = 1'b0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else
            flag <= hit || (flag && !clr);
    end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_timer_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_we,
    input  logic [1:0]    bus_widx,
    input  logic [DW-1:0] bus_wdata,
    input  logic [1:0]    bus_ridx,
    output logic [DW-1:0] bus_rdata,
    input  logic          alt_tick,
    input  logic          halt_in,
    input  logic          rst_arm,
    output logic          irq_cmp1,
    output logic          irq_cmp2,
    output logic          wdt_rst_req
);
    setup_t          cfg_q;
    setup_t          wr_setup;
    setup_t          rd_setup;
    logic [DW-1:0]   cmp_q [NCMP];
    logic [DW-1:0]   cnt_q;
    logic            adv_q;
    logic            wr_cnt, wr_set;
    logic            src_en, tick, frozen;
    cmp_mode_e       mode_w  [NCMP];
    logic [NCMP-1:0] hit_w, reach_w, flag_q, clr_w;
    logic            req_q;

    always_comb begin
        wr_setup = setup_t'(bus_wdata);
        wr_cnt   = bus_we && (reg_sel_e'(bus_widx) == RG_CNT);
        wr_set   = bus_we && (reg_sel_e'(bus_widx) == RG_SETUP);
        frozen   = cfg_q.stop_en && halt_in;
        src_en   = cfg_q.cnt_en && !frozen && (cfg_q.clk_sel ? alt_tick : 1'b1);
        mode_w[0] = cfg_q.mode1;
        mode_w[1] = cfg_q.mode2;
        clr_w[0]  = wr_set && wr_setup.flag1;
        clr_w[1]  = wr_set && wr_setup.flag2;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (wr_set && !cfg_q.lock)
            cfg_q <= strip_status(wr_setup);
    end

    generate
        for (genvar i = 0; i < NCMP; i++) begin : g_cmp
            always_ff @(posedge clk) begin
                if (rst)
                    cmp_q[i] <= '0;
                else if (bus_we && (bus_widx == 2'(i)))
                    cmp_q[i] <= bus_wdata;
            end

            cmt_compare #(.W(DW)) u_cmp (
                .clk   (clk),
                .rst   (rst),
                .mode  (mode_w[i]),
                .cnt   (cnt_q),
                .ref_v (cmp_q[i]),
                .adv   (adv_q),
                .clr   (clr_w[i]),
                .hit   (hit_w[i]),
                .reach (reach_w[i]),
                .flag  (flag_q[i])
            );
        end
    endgenerate

    cmt_prescale #(.PSW(PSW)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .clr    (!cfg_q.cnt_en || wr_cnt),
        .src_en (src_en),
        .code   (cfg_q.pscode),
        .tick   (tick)
    );

    cmt_counter #(.W(DW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_cnt),
        .load_val (bus_wdata),
        .tick     (tick),
        .wrap     (reach_w[1]),
        .cnt      (cnt_q),
        .adv      (adv_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            req_q <= 1'b0;
        else
            req_q <= hit_w[1] && rst_arm;
    end

    always_comb begin
        rd_setup       = cfg_q;
        rd_setup.flag1 = flag_q[0];
        rd_setup.flag2 = flag_q[1];
        case (reg_sel_e'(bus_ridx))
            RG_CMP1: bus_rdata = cmp_q[0];
            RG_CMP2: bus_rdata = cmp_q[1];
            RG_CNT:  bus_rdata = cnt_q;
            default: bus_rdata = rd_setup;
        endcase
    end

    assign irq_cmp1    = flag_q[0];
    assign irq_cmp2    = flag_q[1];
    assign wdt_rst_req = req_q;
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
    import cmp_timer_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          bus_we,
    input logic [1:0]    bus_widx,
    input logic [DW-1:0] bus_wdata,
    input logic          halt_in,
    input logic          rst_arm,
    input logic          irq_cmp1,
    input logic          wdt_rst_req,
    input setup_t        cfg,
    input logic [DW-1:0] cnt
);
    logic cnt_wr, set_wr;
    assign cnt_wr = bus_we && (bus_widx == 2'd2);
    assign set_wr = bus_we && (bus_widx == 2'd3);

    p_arm_gate_r9: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_req |-> $past(rst_arm));

    p_halt_freeze_r12: assert property (@(posedge clk) disable iff (rst)
        (cfg.stop_en && halt_in && !cnt_wr) |=> $stable(cnt));

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_cmp1 && !(set_wr && bus_wdata[13])) |=> irq_cmp1);

    p_lock_hold_r11: assert property (@(posedge clk) disable iff (rst)
        cfg.lock |=> (cfg.lock && $stable(cfg)));

    p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
        !cnt_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) + DW'(1) || cnt == '0));
endmodule

bind cmp_timer cmp_timer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_we      (bus_we),
    .bus_widx    (bus_widx),
    .bus_wdata   (bus_wdata),
    .halt_in     (halt_in),
    .rst_arm     (rst_arm),
    .irq_cmp1    (irq_cmp1),
    .wdt_rst_req (wdt_rst_req),
    .cfg         (cfg_q),
    .cnt         (cnt_q)
);

// File: tb/cmp_timer_tb_top.sv
`timescale 1ns/1ps
module cmp_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_widx = '0;
    logic [15:0] bus_wdata = '0;
    logic [1:0]  bus_ridx = '0;
    logic [15:0] bus_rdata;
    logic        alt_tick = 1'b0;
    logic        halt_in = 1'b0;
    logic        rst_arm = 1'b0;
    logic        irq_cmp1, irq_cmp2, wdt_rst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    localparam logic [1:0] I_C1 = 2'd0, I_C2 = 2'd1, I_CNT = 2'd2, I_SET = 2'd3;

    always #2.5 clk = ~clk;

    cmp_timer dut_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_widx(bus_widx),
        .bus_wdata(bus_wdata), .bus_ridx(bus_ridx), .bus_rdata(bus_rdata),
        .alt_tick(alt_tick), .halt_in(halt_in), .rst_arm(rst_arm),
        .irq_cmp1(irq_cmp1), .irq_cmp2(irq_cmp2), .wdt_rst_req(wdt_rst_req)
    );

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; bus_we = 1'b0; alt_tick = 1'b0; halt_in = 1'b0; rst_arm = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(logic [1:0] idx, logic [15:0] d);
        bus_we = 1'b1; bus_widx = idx; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] idx, output logic [15:0] v);
        bus_ridx = idx;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [15:0] v;
        do_reset();
        for (int i = 0; i < 4; i++) begin
            rd(2'(i), v);
            check("R1 register zero", v, 16'h0);
        end
        check("R1 outputs low", {13'b0, irq_cmp1, irq_cmp2, wdt_rst_req}, 16'h0);
    endtask

    task automatic t_prescale();
        logic [15:0] v;
        do_reset();
        wr(I_SET, 16'h8000);
        wait_n(20); rd(I_CNT, v);
        check("R2 code 0 after 20", v, 16'd20);
        do_reset();
        wr(I_SET, 16'h8003);
        wait_n(23); rd(I_CNT, v);
        check("R2 code 3 after 23", v, 16'd2);
        wait_n(1); rd(I_CNT, v);
        check("R2 code 3 after 24", v, 16'd3);
    endtask

    task automatic t_clk_sel();
        logic [15:0] v;
        do_reset();
        wr(I_SET, 16'h8010);
        wait_n(10); rd(I_CNT, v);
        check("R3 alt source idle", v, 16'd0);
        alt_tick = 1'b1;
        wait_n(5);
        alt_tick = 1'b0;
        wait_n(3); rd(I_CNT, v);
        check("R3 alt source five ticks", v, 16'd5);
    endtask

    task automatic t_equal_and_flags();
        logic [15:0] v;
        do_reset();
        wait_n(3);
        check("R4 off mode no flag", {15'b0, irq_cmp1}, 16'd0);
        wr(I_C1, 16'd5);
        wr(I_SET, 16'h8040);
        wait_n(5); rd(I_CNT, v);
        check("R4 count at compare", v, 16'd5);
        check("R4 flag not yet", {15'b0, irq_cmp1}, 16'd0);
        wait_n(1);
        check("R4 flag set", {15'b0, irq_cmp1}, 16'd1);
        rd(I_SET, v);
        check("R7 flag in setup bit 13", v, 16'hA040);
        wr(I_SET, 16'h8040);
        check("R7 write 0 keeps flag", {15'b0, irq_cmp1}, 16'd1);
        wr(I_SET, 16'hA040);
        check("R7 write 1 clears flag", {15'b0, irq_cmp1}, 16'd0);
    endtask

    task automatic t_ge_mode();
        do_reset();
        wr(I_C1, 16'd10);
        wr(I_CNT, 16'd20);
        wr(I_SET, 16'h0040);
        wait_n(3);
        check("R5 equal mode ignores overshoot", {15'b0, irq_cmp1}, 16'd0);
        wr(I_SET, 16'h0080);
        wait_n(1);
        check("R5 ge mode flags overshoot", {15'b0, irq_cmp1}, 16'd1);
    endtask

    task automatic t_event_mode();
        do_reset();
        wr(I_C1, 16'd7);
        wr(I_CNT, 16'd7);
        wr(I_SET, 16'h00C0);
        wait_n(3);
        check("R6 event ignores written match", {15'b0, irq_cmp1}, 16'd0);
        wr(I_SET, 16'h0040);
        wait_n(1);
        check("R4 equal sees written match", {15'b0, irq_cmp1}, 16'd1);
        do_reset();
        wr(I_C1, 16'd3);
        wr(I_SET, 16'h80C0);
        wait_n(6);
        check("R6 event on counted step", {15'b0, irq_cmp1}, 16'd1);
    endtask

    task automatic t_wrap();
        logic [15:0] v;
        do_reset();
        wr(I_C2, 16'd4);
        wr(I_SET, 16'h8100);
        wait_n(4); rd(I_CNT, v);
        check("R8 reaches compare 2", v, 16'd4);
        wait_n(1); rd(I_CNT, v);
        check("R8 wraps to 0", v, 16'd0);
        wait_n(2); rd(I_CNT, v);
        check("R8 counts on after wrap", v, 16'd2);
        check("R8 compare 2 flag", {15'b0, irq_cmp2}, 16'd1);
        do_reset();
        wr(I_C2, 16'd4);
        wr(I_CNT, 16'd100);
        wr(I_SET, 16'h8200);
        wait_n(1); rd(I_CNT, v);
        check("R8 ge overshoot wraps", v, 16'd0);
    endtask

    task automatic t_reset_req();
        bit seen;
        do_reset();
        rst_arm = 1'b1;
        wr(I_C2, 16'd3);
        wr(I_SET, 16'h8100);
        wait_n(3);
        check("R9 no request before hit", {15'b0, wdt_rst_req}, 16'd0);
        wait_n(1);
        check("R9 request after hit", {15'b0, wdt_rst_req}, 16'd1);
        wait_n(1);
        check("R9 request drops after wrap", {15'b0, wdt_rst_req}, 16'd0);
        do_reset();
        rst_arm = 1'b1;
        wr(I_C2, 16'd10);
        wr(I_SET, 16'h8100);
        seen = 0;
        for (int k = 0; k < 4; k++) begin
            for (int j = 0; j < 5; j++) begin
                @(negedge clk);
                if (wdt_rst_req) seen = 1;
            end
            wr(I_CNT, 16'd0);
        end
        check("R9 restart prevents request", {15'b0, seen}, 16'd0);
        do_reset();
        rst_arm = 1'b0;
        wr(I_C2, 16'd3);
        wr(I_SET, 16'h8100);
        seen = 0;
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            if (wdt_rst_req) seen = 1;
        end
        check("R9 disarmed no request", {15'b0, seen}, 16'd0);
        check("R9 disarmed flag still set", {15'b0, irq_cmp2}, 16'd1);
    endtask

    task automatic t_max_timeout();
        logic [15:0] v;
        do_reset();
        wr(I_C2, 16'hFFFF);
        wr(I_CNT, 16'hFFFE);
        wr(I_SET, 16'h8200);
        wait_n(1); rd(I_CNT, v);
        check("R10 reaches 0xFFFF", v, 16'hFFFF);
        wait_n(1); rd(I_CNT, v);
        check("R10 wraps from 0xFFFF", v, 16'h0000);
        check("R10 flag at max timeout", {15'b0, irq_cmp2}, 16'd1);
    endtask

    task automatic t_lock();
        logic [15:0] v;
        do_reset();
        wr(I_SET, 16'h9000);
        wr(I_SET, 16'h0003);
        rd(I_SET, v);
        check("R11 locked setup unchanged", v, 16'h9000);
        wait_n(4); rd(I_CNT, v);
        check("R11 keeps counting at code 0", v, 16'd5);
        do_reset();
        rd(I_SET, v);
        check("R11 lock cleared by reset", v, 16'h0000);
    endtask

    task automatic t_halt();
        logic [15:0] v;
        do_reset();
        wr(I_SET, 16'h8800);
        wait_n(3);
        halt_in = 1'b1;
        wait_n(5); rd(I_CNT, v);
        check("R12 frozen while halted", v, 16'd3);
        halt_in = 1'b0;
        wait_n(2); rd(I_CNT, v);
        check("R12 resumes after halt", v, 16'd5);
        do_reset();
        wr(I_SET, 16'h8000);
        halt_in = 1'b1;
        wait_n(4); rd(I_CNT, v);
        halt_in = 1'b0;
        check("R12 halt ignored without stop", v, 16'd4);
    endtask

    task automatic t_readback();
        logic [15:0] v;
        do_reset();
        wr(I_C1, 16'h1234);
        wr(I_C2, 16'hBEEF);
        wr(I_CNT, 16'h0042);
        wr(I_SET, 16'h07FF);
        rd(I_C1, v);  check("R13 compare 1 readback", v, 16'h1234);
        rd(I_C2, v);  check("R13 compare 2 readback", v, 16'hBEEF);
        rd(I_SET, v); check("R13 setup bit 10 reads 0", v, 16'h03FF);
        rd(I_CNT, v); check("R13 counter readback", v, 16'h0042);
        do_reset();
        wr(I_SET, 16'h8000);
        wait_n(2);
        wr(I_CNT, 16'h0100);
        rd(I_CNT, v); check("R13 write beats tick", v, 16'h0100);
        wait_n(1); rd(I_CNT, v);
        check("R13 counts from written value", v, 16'h0101);
    endtask

    initial begin
        t_reset_state();
        t_prescale();
        t_clk_sel();
        t_equal_and_flags();
        t_ge_mode();
        t_event_mode();
        t_wrap();
        t_reset_req();
        t_max_timeout();
        t_lock();
        t_halt();
        t_readback();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule